// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, date, month and a two-digit year. A fast clock drives it. A tick-enable input marks the cycles in which the oscillator-derived count advances. A parameterised prescaler turns `PRESCALE` such pulses into one increment of the seconds field. From the seconds field a carry moves through minutes, hours and the calendar fields. The date rolls over according to the length of each month and to leap years.

A host loads any field through a single-byte write port and reads any field back through a combinational read port. The current time also appears on dedicated output ports. Bit 6 of the hours byte selects 12-hour or 24-hour counting. A write to the seconds byte restarts the sub-second prescaler, so the next increment comes one full second after that write. A control byte holds a halt flag that freezes timekeeping. This flag is set out of reset, so the clock does not run until the host has loaded the time.

Top module: `bcd_rtc_core`

## Requirements
- R1: Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control. A write stores only the implemented bits and any other bit reads back as 0. The implemented bits are [6:0] for seconds, minutes and hours, [2:0] for day of week, [5:0] for date, [4:0] for month, all eight for year, and only bit 7 (halt) for control.
- R2: Seconds and minutes count in BCD, carrying from x9 to the next tens digit. Each of them wraps from 59 to 00 and advances the next field.
- R3: With hours bit 6 = 0 (24-hour), bits [5:0] hold BCD hours 00 to 23. Bit 5 is the tens bit that covers 20 to 23. Going from 23 to 00 advances the day.
- R4: With hours bit 6 = 1 (12-hour), bit 5 is PM (1 = PM) and bits [4:0] hold BCD 12, 01 to 11 in that order. Going from 11 to 12 toggles PM. Only 11 PM to 12 AM advances the day.
- R5: The date wraps to 01, and the month advances, after 30 in months 04, 06, 09 and 11, after 31 in all other months, and after 28 or 29 in month 02.
- R6: February has 29 days when the BCD year is divisible by 4, including year 00, and 28 days otherwise.
- R7: Day of week counts 1 to 7 and returns to 1 at midnight. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: A write to the seconds byte clears the prescaler, so the next seconds increment comes after exactly PRESCALE further tick-enable cycles.
- R9: Control bit 7 (halt) is 1 after reset. While it is 1, no field advances, and host writes still take effect.
- R10: A host write to a time field in the same cycle as an increment stores the written value in that field.
- R11: While running, the seconds field advances once per PRESCALE clock cycles with tick_en high, and never in a cycle with tick_en low.
- R12: Reset values are 00:00:00 in 24-hour mode, day of week 1, date 01, month 01 and year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Oscillator tick qualifier for the prescaler |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Register written |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 3 | Register read |
| rd_data | output | 8 | Byte read, unimplemented bits zero |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Hours byte with mode and PM bits |
| wday_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The bench builds the core with PRESCALE = 4, so each second lasts four clock cycles. This keeps every rollover from second to year within a few cycles after a direct load of the preceding value. The short prescaler also makes it possible to place a host write on a chosen count of the prescaler. One case restarts the prescaler two counts into a second. Another case lands a minutes write on the exact cycle of a carry.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);

  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [CW-1:0] presc_q;
  logic          halt_q;
  logic [7:0]    wsel;
  logic          sec_tick, c_min, c_hour, c_day, c_mon, c_year;
  logic          day_wrap, leap;
  logic [1:0]    lsum;
  logic [5:0]    h_inc;
  logic [7:0]    hour_nx, last_day;

  assign wsel     = wr_en ? (8'b1 << wr_addr) : 8'b0;
  assign sec_tick = !halt_q && tick_en && (presc_q == LAST) && !wsel[0];
  assign c_min    = sec_tick && (sec_o == 8'h59);
  assign c_hour   = c_min && (min_o == 8'h59);
  assign c_day    = c_hour && day_wrap;
  assign c_mon    = c_day && (date_o == last_day);
  assign c_year   = c_mon && (month_o == 8'h12);

  assign h_inc = (hour_o[3:0] == 4'd9) ? {hour_o[5:4] + 2'd1, 4'd0}
                                       : {hour_o[5:4], hour_o[3:0] + 4'd1};
  assign lsum  = {year_o[4], 1'b0} + year_o[1:0];
  assign leap  = (lsum == 2'b00);

  always_comb begin
    hour_nx  = hour_o;
    day_wrap = 1'b0;
    if (hour_o[6]) begin
      if (hour_o[4:0] == 5'h11) begin
        hour_nx  = {2'b01, ~hour_o[5], 5'h12};
        day_wrap = hour_o[5];
      end else if (hour_o[4:0] == 5'h12) begin
        hour_nx = {2'b01, hour_o[5], 5'h01};
      end else begin
        hour_nx = {2'b01, h_inc};
      end
    end else if (hour_o[5:0] == 6'h23) begin
      hour_nx  = 8'h00;
      day_wrap = 1'b1;
    end else begin
      hour_nx = {2'b00, h_inc};
    end
  end

  always_comb begin
    case (month_o)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (wsel[0]) begin
      presc_q <= '0;
    end else if (!halt_q && tick_en) begin
      presc_q <= (presc_q == LAST) ? '0 : presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_o   <= 8'h00;
      min_o   <= 8'h00;
      hour_o  <= 8'h00;
      wday_o  <= 8'h01;
      date_o  <= 8'h01;
      month_o <= 8'h01;
      year_o  <= 8'h00;
      halt_q  <= 1'b1;
    end else begin
      if (wsel[0])       sec_o <= wr_data & 8'h7f;
      else if (sec_tick) sec_o <= (sec_o == 8'h59) ? 8'h00 : inc_bcd(sec_o);

      if (wsel[1])       min_o <= wr_data & 8'h7f;
      else if (c_min)    min_o <= (min_o == 8'h59) ? 8'h00 : inc_bcd(min_o);

      if (wsel[2])       hour_o <= wr_data & 8'h7f;
      else if (c_hour)   hour_o <= hour_nx;

      if (wsel[3])       wday_o <= wr_data & 8'h07;
      else if (c_day)    wday_o <= (wday_o == 8'h07) ? 8'h01 : wday_o + 8'h01;

      if (wsel[4])       date_o <= wr_data & 8'h3f;
      else if (c_day)    date_o <= (date_o == last_day) ? 8'h01 : inc_bcd(date_o);

      if (wsel[5])       month_o <= wr_data & 8'h1f;
      else if (c_mon)    month_o <= (month_o == 8'h12) ? 8'h01 : inc_bcd(month_o);

      if (wsel[6])       year_o <= wr_data;
      else if (c_year)   year_o <= (year_o == 8'h99) ? 8'h00 : inc_bcd(year_o);

      if (wsel[7])       halt_q <= wr_data[7];
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = sec_o;
      3'd1:    rd_data = min_o;
      3'd2:    rd_data = hour_o;
      3'd3:    rd_data = wday_o;
      3'd4:    rd_data = date_o;
      3'd5:    rd_data = month_o;
      3'd6:    rd_data = year_o;
      default: rd_data = {halt_q, 7'b0};
    endcase
  end

endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk #(
  parameter int CW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic [2:0]    rd_addr,
  input logic [7:0]    rd_data,
  input logic [7:0]    sec_o,
  input logic [7:0]    hour_o,
  input logic          halt_q,
  input logic [CW-1:0] presc_q
);

  logic sec_wr, hour_wr;
  assign sec_wr  = wr_en && (wr_addr == 3'd0);
  assign hour_wr = wr_en && (wr_addr == 3'd2);

  // R10
  sec_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> (sec_o == ($past(wr_data) & 8'h7f)));

  // R8
  presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> (presc_q == '0));

  // R9
  frozen_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_wr && (halt_q || !tick_en)) |=> $stable(sec_o));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_wr && sec_o == 8'h59) |=> (sec_o == 8'h59 || sec_o == 8'h00));

  // R1
  wday_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd3) |-> (rd_data[7:3] == 5'b0));

  // R1
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd7) |-> (rd_data[6:0] == 7'b0));

  // R4
  pm_midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hour_wr && hour_o == 8'h71) |=> (hour_o == 8'h71 || hour_o == 8'h52));

endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .sec_o(sec_o), .hour_o(hour_o), .halt_q(halt_q), .presc_q(presc_q)
);

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4;
  localparam int NV = 20;

  // {sec,min,hour,wday,date,month,year} loaded, then expected one second later
  localparam logic [111:0] VEC [NV] = '{
    112'h00000001010100_01000001010100,
    112'h09000001010100_10000001010100,
    112'h59592307311299_00000001010100,
    112'h59592303280223_00000004010323,
    112'h59592303280224_00000004290224,
    112'h59592304290224_00000005010324,
    112'h59592302300405_00000003010505,
    112'h59592302310105_00000003010205,
    112'h59592302280212_00000003290212,
    112'h59592302280210_00000003010310,
    112'h59595102050607_00007202050607,
    112'h59597102050607_00005203060607,
    112'h59597202050607_00006102050607,
    112'h59590902050607_00001002050607,
    112'h59591902050607_00002002050607,
    112'h59592305300907_00000006011007,
    112'h59592305301100_00000006011200,
    112'h59592301280200_00000002290200,
    112'h59596904150815_00007004150815,
    112'h59290101010101_00300101010101
  };
  localparam string VTAG [NV] = '{
    "R11", "R2", "R7", "R5 R6", "R6", "R5 R6", "R5", "R5", "R6", "R6",
    "R4", "R4", "R4", "R3", "R3", "R5 R7", "R5", "R6", "R4", "R2"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data, sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_rtc_core #(.PRESCALE(PRE)) u_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic load(input logic [55:0] t);
    wr(3'd7, 8'h80);
    for (int i = 0; i < 7; i++) wr(3'(i), t[55 - 8*i -: 8]);
  endtask

  function automatic logic [55:0] now();
    return {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [55:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset values, R9 halt set out of reset
    chk("R12 reset time", 64'(now()), 64'h00000001010100);
    rd(3'd7, v); chk("R9 halt after reset", 64'(v), 64'h80);
    repeat (5 * PRE) @(posedge clk);
    @(negedge clk);
    chk("R9 frozen after reset", 64'(now()), 64'h00000001010100);

    // R1 unimplemented bits read zero
    wr(3'd0, 8'hff); rd(3'd0, v); chk("R1 sec mask", 64'(v), 64'h7f);
    wr(3'd3, 8'hff); rd(3'd3, v); chk("R1 wday mask", 64'(v), 64'h07);
    wr(3'd4, 8'hff); rd(3'd4, v); chk("R1 date mask", 64'(v), 64'h3f);
    wr(3'd5, 8'hff); rd(3'd5, v); chk("R1 month mask", 64'(v), 64'h1f);
    wr(3'd7, 8'hff); rd(3'd7, v); chk("R1 ctrl mask", 64'(v), 64'h80);

    for (int n = 0; n < NV; n++) begin
      load(VEC[n][111:56]);
      wr(3'd7, 8'h00);
      repeat (PRE) @(posedge clk);
      @(negedge clk);
      chk($sformatf("%s vector %0d", VTAG[n], n), 64'(now()), 64'(VEC[n][55:0]));
      wr(3'd7, 8'h80);
    end

    // R8 seconds write restarts the prescaler
    load(56'h05000001010100);
    wr(3'd7, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(3'd0, 8'h10);
    repeat (PRE - 1) @(posedge clk);
    @(negedge clk);
    chk("R8 no early tick", 64'(sec_o), 64'h10);
    @(posedge clk);
    @(negedge clk);
    chk("R8 tick after full period", 64'(sec_o), 64'h11);
    wr(3'd7, 8'h80);

    // R10 write wins over carry in the same cycle
    load(56'h59100501010100);
    wr(3'd7, 8'h00);
    repeat (PRE - 1) @(posedge clk);
    @(negedge clk);
    wr(3'd1, 8'h30);
    chk("R10 write beats carry", 64'(now()), 64'h00300501010100);

    // R11 no advance with tick_en low
    tick_en = 1'b0;
    snap = now();
    repeat (3 * PRE) @(posedge clk);
    @(negedge clk);
    chk("R11 tick_en low", 64'(now()), 64'(snap));
    tick_en = 1'b1;

    // R9 halt mid-run freezes, writes still land
    wr(3'd7, 8'h80);
    snap = now();
    repeat (3 * PRE) @(posedge clk);
    @(negedge clk);
    chk("R9 halted freeze", 64'(now()), 64'(snap));
    wr(3'd6, 8'h42);
    chk("R9 write while halted", 64'(year_o), 64'h42);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule